// File: doc/BRIEF.md
# Serial Link Bring-Up Sequencer

This block sits beside the root-port controller of a serial point-to-point link and runs the staged start-up of that link. A start pulse makes it rewrite the advertised speed ceiling in the controller's configuration space to first generation, using a read followed by a masked write. It then enables the training state machine and waits for the link to report itself up. If the configured target is second generation, it lifts the ceiling. It then requests a directed speed change and polls until the controller reports that change as finished. A second link check follows, and on success the block reads back the negotiated generation.

All register traffic goes out through one master port with a valid/ready request channel and a single-beat response channel. At most one request is outstanding. The responder may hold off a request by keeping ready low for any number of cycles, and may return the response any number of cycles after acceptance. Every request, read or write, receives exactly one response beat.

When any stage times out, the block drops the training enable and drives the receiver data-enable and PLL-enable overrides of the PHY high together for a fixed hold period. After the hold it raises a failure flag, and a code identifies the failing stage.

Top module: `link_bringup_seq`

## Requirements
- R1: While reset is held and afterwards until a start, `done`, `fail`, `train_en`, `cfg_req_valid` and `phy_rx_ovr` are low and `fail_code` is 0.
- R2: After start, the block reads offset 0x07C and writes back the same word with bits 3:0 set to 1, leaving every other bit unchanged. Both accesses complete before `train_en` rises.
- R3: The link counts as up only when `link_up` is 1 and `in_training` is 0 in the same cycle. If this condition is absent for `wait_limit`+1 consecutive cycles of a wait stage, the first wait fails with code 1.
- R4: After the first link-up with `max_gen` equal to 2, offset 0x07C is read again and written with bits 3:0 set to 2 and the other bits kept. For any other `max_gen` value no second access to 0x07C is made.
- R5: The directed speed change is a read of offset 0x80C followed by a write of the same word with bit 17 set.
- R6: After that write, 0x80C is re-read until bit 17 reads 0. The limit is POLL_MAX reads. A 0 seen on the last permitted read counts as completion. If POLL_MAX reads all return 1, the sequence fails with code 2.
- R7: After completion, the link-up condition of R3 is awaited again under the same limit. A timeout here fails with code 3.
- R8: On success, offset 0x080 is read, `neg_gen` takes bits 19:16 of the returned word, and `done` rises. `neg_gen` stays constant and `train_en` stays high while `done` is high. `done` and `fail` are never high together.
- R9: On any failure, `train_en` falls at once and `phy_rx_ovr` (bit 0 receiver data enable, bit 1 receiver PLL enable) is 2'b11 for exactly RX_HOLD cycles, then 2'b00. `fail` then rises with the stage code (1, 2 or 3), and no request is issued during the hold.
- R10: Once raised, `cfg_req_valid` stays high with stable write flag, address and data until `cfg_req_ready` is seen. The next request is not raised until the response beat for the current one has arrived.
- R11: `start` is taken only when idle, done or failed. It clears `done`, `fail`, `fail_code` and `neg_gen` and restarts from R2. A start pulse during a running sequence has no effect on the register accesses or the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up sequence |
| max_gen | input | 2 | Target generation; 2 allows second generation, other values keep first |
| wait_limit | input | WAIT_W | Cycle limit for each link-up wait |
| link_up | input | 1 | Link reports up |
| in_training | input | 1 | Link training in progress |
| train_en | output | 1 | Enable for the training state machine |
| cfg_req_valid | output | 1 | Register request valid |
| cfg_req_ready | input | 1 | Register request accepted |
| cfg_req_write | output | 1 | 1 for write, 0 for read |
| cfg_req_addr | output | ADDR_W | Configuration-space byte offset |
| cfg_req_wdata | output | DATA_W | Write data |
| cfg_rsp_valid | input | 1 | Response beat for the accepted request |
| cfg_rsp_rdata | input | DATA_W | Read data carried by the response beat |
| phy_rx_ovr | output | 2 | Receiver override pulse: bit 0 data enable, bit 1 PLL enable |
| done | output | 1 | Sequence finished with the link up |
| fail | output | 1 | Sequence ended in failure |
| fail_code | output | 2 | Failing stage: 0 none, 1 first wait, 2 speed change, 3 second wait |
| neg_gen | output | 4 | Negotiated generation from the status word |

## Verification
Two decisions can land on the same response beat: the speed-change completion (bit 17 reading 0) and the exhaustion of the poll limit. The bench's controller model clears the bit on exactly the two-hundredth read. It expects completion to win, followed by the second link wait and the status read. A companion case never clears the bit and expects exactly POLL_MAX reads before code 2. A third case holds the link up but still in training, and confirms that no access beyond the speed-ceiling write appears until training ends.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

  // Configuration-space offsets the sequence touches
  localparam logic [11:0] CAP_OFS = 12'h07C;  // speed ceiling in bits 3:0
  localparam logic [11:0] LCS_OFS = 12'h080;  // negotiated generation in bits 19:16
  localparam logic [11:0] SPD_OFS = 12'h80C;  // directed speed change request bit

  localparam int SPD_REQ_BIT = 17;
  localparam int GEN_LSB     = 16;

  typedef enum logic [1:0] {
    FC_NONE    = 2'd0,
    FC_LINK    = 2'd1,
    FC_SPEED   = 2'd2,
    FC_RECHECK = 2'd3
  } fail_code_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CAP_RD,
    S_CAP_WR,
    S_WAIT1,
    S_UP_RD,
    S_UP_WR,
    S_SPD_RD,
    S_SPD_WR,
    S_POLL,
    S_WAIT2,
    S_GEN_RD,
    S_DONE,
    S_RECOVER,
    S_FAILED
  } seq_state_t;

endpackage

// File: rtl/link_span_counter.sv
module link_span_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/link_cfg_port.sv
module link_cfg_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  // from the sequencer
  input  logic              op_go,
  input  logic              op_write,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_wdata,
  output logic              op_done,
  output logic [DATA_W-1:0] op_rdata,
  // toward the controller
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata
);

  typedef enum logic [1:0] {P_IDLE, P_REQ, P_RSP} port_state_t;
  port_state_t pst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst       <= P_IDLE;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      unique case (pst)
        P_IDLE: if (op_go) begin
          pst       <= P_REQ;
          req_write <= op_write;
          req_addr  <= op_addr;
          req_wdata <= op_wdata;
        end
        P_REQ:   if (req_ready) pst <= P_RSP;
        P_RSP:   if (rsp_valid) pst <= P_IDLE;
        default: pst <= P_IDLE;
      endcase
    end
  end

  assign req_valid = (pst == P_REQ);
  assign op_done   = (pst == P_RSP) && rsp_valid;
  assign op_rdata  = rsp_rdata;

endmodule

// File: rtl/link_rx_recovery.sv
module link_rx_recovery #(
  parameter int RX_HOLD = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kick,
  output logic [1:0] ovr,
  output logic       fin
);

  localparam int HOLD_W = $clog2(RX_HOLD + 1);

  logic              active;
  logic [HOLD_W-1:0] hcnt;

  link_span_counter #(.W(HOLD_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (kick || !active),
    .inc   (active),
    .cnt   (hcnt)
  );

  assign fin = active && (hcnt == HOLD_W'(RX_HOLD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    active <= 1'b0;
    else if (kick) active <= 1'b1;
    else if (fin)  active <= 1'b0;
  end

  assign ovr = {2{active}};

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import link_seq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int WAIT_W   = 16,
  parameter int POLL_MAX = 200,
  parameter int RX_HOLD  = 400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        max_gen,
  input  logic [WAIT_W-1:0] wait_limit,
  input  logic              link_up,
  input  logic              in_training,
  output logic              train_en,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic [ADDR_W-1:0] cfg_req_addr,
  output logic [DATA_W-1:0] cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [DATA_W-1:0] cfg_rsp_rdata,
  output logic [1:0]        phy_rx_ovr,
  output logic              done,
  output logic              fail,
  output logic [1:0]        fail_code,
  output logic [3:0]        neg_gen
);

  localparam int POLL_W = $clog2(POLL_MAX + 1);

  seq_state_t        st;
  logic [DATA_W-1:0] rd_q;

  logic              bus_go, bus_write, op_done;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, op_rdata;

  logic              link_ok, waiting, wait_expired;
  logic [WAIT_W-1:0] wcnt;
  logic [POLL_W-1:0] pcnt;
  logic              poll_last, spd_busy;
  logic              go_fail, start_ok, rec_fin;
  fail_code_t        code_next;

  // ---------------- register access engine
  link_cfg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_go     (bus_go),
    .op_write  (bus_write),
    .op_addr   (bus_addr),
    .op_wdata  (bus_wdata),
    .op_done   (op_done),
    .op_rdata  (op_rdata),
    .req_valid (cfg_req_valid),
    .req_ready (cfg_req_ready),
    .req_write (cfg_req_write),
    .req_addr  (cfg_req_addr),
    .req_wdata (cfg_req_wdata),
    .rsp_valid (cfg_rsp_valid),
    .rsp_rdata (cfg_rsp_rdata)
  );

  always_comb begin
    bus_go    = 1'b0;
    bus_write = 1'b0;
    bus_addr  = ADDR_W'(CAP_OFS);
    bus_wdata = '0;
    unique case (st)
      S_CAP_RD, S_UP_RD: bus_go = 1'b1;
      S_CAP_WR: begin
        bus_go    = 1'b1;
        bus_write = 1'b1;
        bus_wdata = {rd_q[DATA_W-1:4], 4'h1};
      end
      S_UP_WR: begin
        bus_go    = 1'b1;
        bus_write = 1'b1;
        bus_wdata = {rd_q[DATA_W-1:4], 4'h2};
      end
      S_SPD_RD, S_POLL: begin
        bus_go   = 1'b1;
        bus_addr = ADDR_W'(SPD_OFS);
      end
      S_SPD_WR: begin
        bus_go    = 1'b1;
        bus_write = 1'b1;
        bus_addr  = ADDR_W'(SPD_OFS);
        bus_wdata = rd_q | (DATA_W'(1) << SPD_REQ_BIT);
      end
      S_GEN_RD: begin
        bus_go   = 1'b1;
        bus_addr = ADDR_W'(LCS_OFS);
      end
      default: ;
    endcase
  end

  // ---------------- link wait window
  assign link_ok = link_up && !in_training;
  assign waiting = (st == S_WAIT1) || (st == S_WAIT2);

  link_span_counter #(.W(WAIT_W)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!waiting),
    .inc   (waiting),
    .cnt   (wcnt)
  );

  assign wait_expired = waiting && !link_ok && (wcnt == wait_limit);

  // ---------------- speed-change poll budget
  link_span_counter #(.W(POLL_W)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st != S_POLL),
    .inc   ((st == S_POLL) && op_done),
    .cnt   (pcnt)
  );

  assign poll_last = (pcnt == POLL_W'(POLL_MAX - 1));
  assign spd_busy  = op_rdata[SPD_REQ_BIT];

  // ---------------- failure detection and recovery pulse
  always_comb begin
    go_fail   = 1'b0;
    code_next = FC_NONE;
    if (st == S_WAIT1 && wait_expired) begin
      go_fail   = 1'b1;
      code_next = FC_LINK;
    end else if (st == S_POLL && op_done && spd_busy && poll_last) begin
      go_fail   = 1'b1;
      code_next = FC_SPEED;
    end else if (st == S_WAIT2 && wait_expired) begin
      go_fail   = 1'b1;
      code_next = FC_RECHECK;
    end
  end

  link_rx_recovery #(.RX_HOLD(RX_HOLD)) u_recover (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (go_fail),
    .ovr   (phy_rx_ovr),
    .fin   (rec_fin)
  );

  assign start_ok = start && (st == S_IDLE || st == S_DONE || st == S_FAILED);

  // ---------------- stage sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rd_q      <= '0;
      train_en  <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_code <= FC_NONE;
      neg_gen   <= '0;
    end else if (start_ok) begin
      st        <= S_CAP_RD;
      train_en  <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_code <= FC_NONE;
      neg_gen   <= '0;
    end else if (go_fail) begin
      st        <= S_RECOVER;
      train_en  <= 1'b0;
      fail_code <= code_next;
    end else begin
      unique case (st)
        S_CAP_RD: if (op_done) begin rd_q <= op_rdata; st <= S_CAP_WR; end
        S_CAP_WR: if (op_done) begin train_en <= 1'b1; st <= S_WAIT1; end
        S_WAIT1:  if (link_ok) st <= (max_gen == 2'd2) ? S_UP_RD : S_SPD_RD;
        S_UP_RD:  if (op_done) begin rd_q <= op_rdata; st <= S_UP_WR; end
        S_UP_WR:  if (op_done) st <= S_SPD_RD;
        S_SPD_RD: if (op_done) begin rd_q <= op_rdata; st <= S_SPD_WR; end
        S_SPD_WR: if (op_done) st <= S_POLL;
        S_POLL:   if (op_done && !spd_busy) st <= S_WAIT2;
        S_WAIT2:  if (link_ok) st <= S_GEN_RD;
        S_GEN_RD: if (op_done) begin
          neg_gen <= op_rdata[GEN_LSB +: 4];
          done    <= 1'b1;
          st      <= S_DONE;
        end
        S_RECOVER: if (rec_fin) begin fail <= 1'b1; st <= S_FAILED; end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/link_bringup_checks.sv
module link_bringup_checks #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              train_en,
  input logic              cfg_req_valid,
  input logic              cfg_req_ready,
  input logic              cfg_req_write,
  input logic [ADDR_W-1:0] cfg_req_addr,
  input logic [DATA_W-1:0] cfg_req_wdata,
  input logic [1:0]        phy_rx_ovr,
  input logic              done,
  input logic              fail,
  input logic [1:0]        fail_code,
  input logic [3:0]        neg_gen
);

  assert_done_fail_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  assert_done_train_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> train_en && fail_code == 2'd0);

  assert_gen_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(done) |-> $stable(neg_gen));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_req_write)
      && $stable(cfg_req_addr) && $stable(cfg_req_wdata));

  assert_ovr_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phy_rx_ovr) != 1);

  assert_ovr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rx_ovr != 2'b00 |-> !train_en && !cfg_req_valid && !fail);

  assert_fail_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> fail_code != 2'd0 && !train_en && phy_rx_ovr == 2'b00);

endmodule

bind link_bringup_seq link_bringup_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .train_en      (train_en),
  .cfg_req_valid (cfg_req_valid),
  .cfg_req_ready (cfg_req_ready),
  .cfg_req_write (cfg_req_write),
  .cfg_req_addr  (cfg_req_addr),
  .cfg_req_wdata (cfg_req_wdata),
  .phy_rx_ovr    (phy_rx_ovr),
  .done          (done),
  .fail          (fail),
  .fail_code     (fail_code),
  .neg_gen       (neg_gen)
);

// File: tb/tb_link_bringup_seq.sv
`timescale 1ns/1ps
module tb_link_bringup_seq;

  localparam int HOLD = 40;
  localparam int PMAX = 200;
  localparam logic [11:0] A_CAP = 12'h07C;
  localparam logic [11:0] A_LCS = 12'h080;
  localparam logic [11:0] A_SPD = 12'h80C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  max_gen = 2'd1;
  logic [15:0] wait_limit = 16'd100;
  logic        link_up = 1'b0;
  logic        in_training = 1'b0;
  logic        train_en;
  logic        cfg_req_valid;
  logic        cfg_req_ready = 1'b0;
  logic        cfg_req_write;
  logic [11:0] cfg_req_addr;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;
  logic [1:0]  phy_rx_ovr;
  logic        done, fail;
  logic [1:0]  fail_code;
  logic [3:0]  neg_gen;

  always #2.5 clk = ~clk;

  link_bringup_seq #(.POLL_MAX(PMAX), .RX_HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .max_gen(max_gen),
    .wait_limit(wait_limit), .link_up(link_up), .in_training(in_training),
    .train_en(train_en), .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_req_write(cfg_req_write), .cfg_req_addr(cfg_req_addr),
    .cfg_req_wdata(cfg_req_wdata), .cfg_rsp_valid(cfg_rsp_valid),
    .cfg_rsp_rdata(cfg_rsp_rdata), .phy_rx_ovr(phy_rx_ovr), .done(done),
    .fail(fail), .fail_code(fail_code), .neg_gen(neg_gen)
  );

  int checks = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- controller model
  typedef struct { bit w; logic [11:0] a; logic [31:0] d; } txn_t;
  txn_t expq[$];

  logic [31:0] m_cap, m_spd, m_lcs;
  int  spd_k = 0;
  int  spd_reads = 0;
  bit  spd_armed = 0;
  bit  drop_on_spd = 0;
  bit  link_kill = 0;
  int  link_delay = -1;
  int  trn_len = 0;
  int  n_txn = 0;

  task automatic take_request(output logic [31:0] rd);
    txn_t e;
    rd = '0;
    n_txn++;
    if (expq.size() == 0) begin
      check(0, "R11", "unexpected request addr", longint'(cfg_req_addr), 0);
    end else begin
      e = expq.pop_front();
      check(e.w == cfg_req_write && e.a == cfg_req_addr, "R10",
            "request kind/addr", {cfg_req_write, cfg_req_addr}, {e.w, e.a});
      if (e.w)
        check(e.d == cfg_req_wdata, "R5", "write data", cfg_req_wdata, e.d);
    end
    if (cfg_req_write) begin
      if (cfg_req_addr == A_CAP) m_cap = cfg_req_wdata;
      if (cfg_req_addr == A_SPD) begin
        m_spd = cfg_req_wdata;
        if (cfg_req_wdata[17]) begin
          spd_armed = 1;
          spd_reads = 0;
          if (drop_on_spd) link_kill = 1;
        end
      end
    end else begin
      if (cfg_req_addr == A_CAP) rd = m_cap;
      else if (cfg_req_addr == A_LCS) rd = m_lcs;
      else if (cfg_req_addr == A_SPD) begin
        if (spd_armed) begin
          spd_reads++;
          if (spd_k != 0 && spd_reads >= spd_k) begin
            m_spd[17] = 1'b0;
            spd_armed = 0;
          end
        end
        rd = m_spd;
      end
    end
  endtask

  // responder: accepts after a stall, answers after a delay
  initial begin
    int bst = 0;
    int stall = 0;
    int rwait = 0;
    logic [31:0] rsp_d = '0;
    forever begin
      @(negedge clk);
      cfg_rsp_valid = 1'b0;
      if (!rst_n) begin
        bst = 0;
        cfg_req_ready = 1'b0;
      end else begin
        case (bst)
          0: if (cfg_req_valid) begin
               if (stall == 0) begin
                 cfg_req_ready = 1'b1;
                 take_request(rsp_d);
                 bst = 1;
               end else stall--;
             end
          1: begin
               cfg_req_ready = 1'b0;
               rwait = n_txn % 2;
               bst = 2;
             end
          default: begin
               if (rwait == 0) begin
                 cfg_rsp_valid = 1'b1;
                 cfg_rsp_rdata = rsp_d;
                 stall = n_txn % 3;
                 bst = 0;
               end else rwait--;
             end
        endcase
      end
    end
  end

  // link model
  initial begin
    int lcnt = 0;
    forever begin
      @(negedge clk);
      if (!train_en) begin
        link_up = 1'b0;
        in_training = 1'b0;
        lcnt = 0;
      end else begin
        lcnt++;
        if (link_kill) begin
          link_up = 1'b0;
          in_training = 1'b0;
        end else if (link_delay >= 0 && lcnt == link_delay) begin
          link_up = 1'b1;
          in_training = (trn_len > 0);
        end else if (trn_len > 0 && lcnt == link_delay + trn_len) begin
          in_training = 1'b0;
        end
      end
    end
  end

  task automatic push(input bit w, input logic [11:0] a, input logic [31:0] d);
    txn_t t;
    t.w = w; t.a = a; t.d = d;
    expq.push_back(t);
  endtask

  task automatic run_case(input string nm, input int gen, input int lim,
                          input int ldel, input int tlen, input int k,
                          input int lgen, input bit drop, input bit mid);
    logic [31:0] cap0, capv, spd0;
    int  npoll, exp_code, ovr_cycles, cyc, exp_nib;
    bit  link1_ok, poll_ok, prev_tr, seen_fall;
    cap0 = 32'h5A3C_9E47;
    spd0 = 32'h0004_1A05;
    m_cap = cap0;
    m_spd = spd0;
    m_lcs = (32'h0031_0041 & ~32'h000F_0000) | (32'(lgen) << 16);
    spd_k = k; spd_armed = 0; spd_reads = 0;
    drop_on_spd = drop; link_kill = 0;
    link_delay = ldel; trn_len = tlen;
    max_gen = 2'(gen); wait_limit = 16'(lim);
    n_txn = 0;
    expq.delete();

    link1_ok = (ldel >= 0) && (ldel + tlen < lim);
    npoll = (k == 0 || k > PMAX) ? PMAX : k;
    poll_ok = (k != 0 && k <= PMAX);
    push(0, A_CAP, '0);
    capv = {cap0[31:4], 4'h1};
    push(1, A_CAP, capv);
    exp_nib = 1;
    if (link1_ok) begin
      if (gen == 2) begin
        push(0, A_CAP, '0);
        push(1, A_CAP, {capv[31:4], 4'h2});
        exp_nib = 2;
      end
      push(0, A_SPD, '0);
      push(1, A_SPD, spd0 | 32'h0002_0000);
      for (int i = 0; i < npoll; i++) push(0, A_SPD, '0);
      if (poll_ok && !drop) push(0, A_LCS, '0);
    end
    exp_code = !link1_ok ? 1 : (!poll_ok ? 2 : (drop ? 3 : 0));

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    ovr_cycles = 0; cyc = 0; prev_tr = 0; seen_fall = 0;
    while (!(done || fail)) begin
      if (phy_rx_ovr == 2'b11) ovr_cycles++;
      if (prev_tr && !in_training && !seen_fall) begin
        seen_fall = 1;
        check(n_txn == 2, "R3", {nm, " accesses while still training"}, n_txn, 2);
      end
      prev_tr = in_training;
      @(negedge clk);
      cyc++;
      start = (mid && cyc == 30);
      if (cyc > 20000) begin
        check(0, "R8", {nm, " watchdog expired"}, cyc, 0);
        break;
      end
    end
    start = 1'b0;
    check(done == (exp_code == 0) && fail == (exp_code != 0), "R8",
          {nm, " done/fail"}, {done, fail}, {exp_code == 0, exp_code != 0});
    check(fail_code == 2'(exp_code), (exp_code == 2) ? "R6" : (exp_code == 3) ? "R7" : "R3",
          {nm, " fail code"}, fail_code, exp_code);
    if (exp_code == 0)
      check(neg_gen == 4'(lgen), "R8", {nm, " negotiated gen"}, neg_gen, lgen);
    check(expq.size() == 0, "R6", {nm, " missing accesses"}, expq.size(), 0);
    check(m_cap[3:0] == 4'(exp_nib), "R4", {nm, " speed ceiling"}, m_cap[3:0], exp_nib);
    check(train_en == (exp_code == 0), "R9", {nm, " training enable"}, train_en, exp_code == 0);
    check(ovr_cycles == ((exp_code != 0) ? HOLD : 0), "R9", {nm, " override cycles"},
          ovr_cycles, (exp_code != 0) ? HOLD : 0);
    repeat (3) @(negedge clk);
    check(phy_rx_ovr == 2'b00, "R9", {nm, " override released"}, phy_rx_ovr, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!done && !fail && fail_code == 0, "R1", "status in reset", {done, fail, fail_code}, 0);
    check(!train_en && !cfg_req_valid && phy_rx_ovr == 0, "R1", "outputs in reset",
          {train_en, cfg_req_valid, phy_rx_ovr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !fail && !cfg_req_valid && !train_en, "R1", "idle after reset",
          {done, fail, cfg_req_valid, train_en}, 0);

    // R2 R5 R11: first-generation target, start pulsed mid-run
    run_case("gen1", 1, 100, 5, 0, 3, 1, 0, 1);
    // R3 R4: link up but still training for a while, second-generation target
    run_case("gen2_training", 2, 100, 3, 12, 1, 2, 0, 0);
    // R6: completion on the final permitted poll
    run_case("poll_edge", 2, 100, 4, 0, PMAX, 2, 0, 0);
    // R6 R9: speed change never completes
    run_case("poll_timeout", 1, 100, 4, 0, 0, 1, 0, 0);
    // R3 R9: link never comes up
    run_case("no_link", 2, 20, -1, 0, 1, 1, 0, 0);
    // R7 R9: link lost after the speed change
    run_case("recheck_lost", 1, 25, 2, 0, 2, 1, 1, 0);
    // R11: restart from failed state, R4 with max_gen 3 keeps Gen1
    run_case("restart", 3, 100, 6, 0, 5, 1, 0, 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule